// File: doc/BRIEF.md
# Serial ADC Link Controller

This block is a synchronous master for a four-channel, 12-bit successive-approximation converter that sits on a four-wire serial link. A one-cycle start request makes the block lower chip select. The converter samples its input and begins converting at that moment. The block then runs sixteen serial clock periods. During these periods it sends a 16-bit control word to the converter and collects the 16-bit result frame coming back, with the most significant bit first on both lines. There is no pipeline delay, so the captured frame belongs to the conversion that the same chip-select window started.

The serial clock comes from the system clock through a programmable half-period divider. The clock rests high whenever chip select is high. After chip select rises, a programmable quiet interval must pass before a new request is taken. The controller splits each returned frame into a leading pair of bits, a 2-bit channel tag and a 12-bit sample. It applies the requested sample coding and compares the tag with the channel the caller expects. It then issues a one-cycle result strobe.

The controller is built around five states:
- IDLE waits for a request.
- LEAD holds chip select low with the clock high.
- LOW and HIGH are the two halves of each serial clock period.
- QUIET enforces the gap after chip select rises.

The transitions are:
- IDLE to LEAD on a start.
- LEAD to LOW after one half period (this is the first falling edge).
- LOW to HIGH after each low half.
- HIGH to LOW after each high half, while fewer than sixteen falling edges have occurred.
- HIGH to QUIET after the high half that follows the sixteenth falling edge. Chip select rises and the result is strobed at this point.
- QUIET to IDLE when the quiet count expires.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset, chip select and the serial clock are high, busy is low and the result strobe is low.
- R2: A start sampled in the idle state lowers chip select and raises busy on the next cycle. A start sampled while busy has no effect on the frame in progress.
- R3: Each serial clock half period lasts H system cycles, where H is the divider input, and a value of 0 acts as 1. The first falling edge comes H cycles after chip select falls. Exactly sixteen falling edges occur per frame. The serial clock is high whenever chip select is high.
- R4: The control word goes out MSB first on data-in. Bit 15 appears when chip select falls, and each following bit is driven at a rising edge. Data-in therefore stays stable across every falling edge, where the converter latches it.
- R5: Data-out is sampled in the cycle the block drives each falling edge, before the converter can update it. The first sample taken becomes frame bit 15 and the sixteenth becomes frame bit 0.
- R6: Frame bits 15:14 are the leading pair, bits 13:12 are the channel tag reported on the channel output, and bits 11:0 are the sample.
- R7: When the coding select is 1, the reported sample is the straight binary value with bit 11 inverted (two's complement). When it is 0, the value passes through unchanged. The coding flag output reports the select that was used.
- R8: The error flag is set with the result when the leading pair is not 00 or when the tag differs from the expected channel captured at start.
- R9: Chip select rises H cycles after the sixteenth rising edge. The result strobe is high for exactly that one cycle.
- R10: Busy stays high for Q cycles after chip select rises, where Q is the quiet input, and a value of 0 acts as 1. Chip select therefore stays high for at least Q+1 cycles between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion frame |
| ctrl_word_i | input | 16 | Control word sent to the converter |
| half_div_i | input | DIV_W | Serial clock half period in system cycles |
| quiet_i | input | QUIET_W | Minimum quiet cycles after chip select rises |
| twos_i | input | 1 | 1 selects two's complement sample coding |
| exp_chan_i | input | 2 | Channel expected in this frame |
| busy_o | output | 1 | Frame or quiet interval in progress |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| din_o | output | 1 | Serial data to the converter |
| dout_i | input | 1 | Serial data from the converter |
| valid_o | output | 1 | One-cycle result strobe |
| chan_o | output | 2 | Channel tag of the result |
| sample_o | output | 12 | Coded sample |
| twos_o | output | 1 | Coding used for sample_o |
| err_o | output | 1 | Leading-bit or channel mismatch |

## Verification
The hardest situation to reach is a start request held across an entire frame and its quiet interval. The request must be ignored while busy and accepted again only after QUIET ends. The stimulus holds start high for longer than a whole short-divider frame. The behavioural model then predicts the back-to-back second frame and its exact chip-select gap. A converter model also replays frames with non-zero leading bits and mismatched tags to drive the error flag, and it shifts in the control word on the observed falling edges so the data-in timing can be checked.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CHAN_W     = 2;
    localparam int SAMPLE_W   = 12;
    localparam int LEAD_W     = FRAME_BITS - CHAN_W - SAMPLE_W;
    localparam int BITCNT_W   = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_QUIET
    } link_state_t;
endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else              cnt_q <= cnt_q + W'(1);
    end

    assign done_o = (cnt_q == limit_i - W'(1));
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
    import adc_link_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [FRAME_BITS-1:0] word_i,
    input  logic                  advance_i,
    input  logic                  capture_i,
    input  logic                  rx_bit_i,
    output logic                  tx_bit_o,
    output logic [FRAME_BITS-1:0] rx_word_o
);
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tx_q <= '0;
        else if (load_i)    tx_q <= word_i;
        else if (advance_i) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rx_q <= '0;
        else if (load_i)    rx_q <= '0;
        else if (capture_i) rx_q <= {rx_q[FRAME_BITS-2:0], rx_bit_i};
    end

    assign tx_bit_o  = tx_q[FRAME_BITS-1];
    assign rx_word_o = rx_q;
endmodule

// File: rtl/adc_result_decode.sv
module adc_result_decode
    import adc_link_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  twos_i,
    input  logic [CHAN_W-1:0]     exp_chan_i,
    output logic [CHAN_W-1:0]     chan_o,
    output logic [SAMPLE_W-1:0]   sample_o,
    output logic                  err_o
);
    logic [LEAD_W-1:0]   lead_bits;
    logic [SAMPLE_W-1:0] raw;

    always_comb begin
        lead_bits = frame_i[FRAME_BITS-1 -: LEAD_W];
        chan_o    = frame_i[SAMPLE_W +: CHAN_W];
        raw       = frame_i[SAMPLE_W-1:0];
        sample_o  = twos_i ? {~raw[SAMPLE_W-1], raw[SAMPLE_W-2:0]} : raw;
        err_o     = (lead_bits != '0) || (chan_o != exp_chan_i);
    end
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
    import adc_link_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int QUIET_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] ctrl_word_i,
    input  logic [DIV_W-1:0]      half_div_i,
    input  logic [QUIET_W-1:0]    quiet_i,
    input  logic                  twos_i,
    input  logic [CHAN_W-1:0]     exp_chan_i,
    output logic                  busy_o,
    output logic                  cs_n_o,
    output logic                  sclk_o,
    output logic                  din_o,
    input  logic                  dout_i,
    output logic                  valid_o,
    output logic [CHAN_W-1:0]     chan_o,
    output logic [SAMPLE_W-1:0]   sample_o,
    output logic                  twos_o,
    output logic                  err_o
);
    localparam int TMR_W = (DIV_W > QUIET_W) ? DIV_W : QUIET_W;

    link_state_t state_q, state_d;

    logic [DIV_W-1:0]    half_q;
    logic [QUIET_W-1:0]  quiet_q;
    logic                twos_q;
    logic [CHAN_W-1:0]   exp_q;
    logic [BITCNT_W-1:0] falls_q;
    logic                cs_n_q, sclk_q, busy_q, valid_q;
    logic [CHAN_W-1:0]   chan_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic                twos_out_q, err_q;

    logic [TMR_W-1:0]      tmr_limit;
    logic                  tmr_done, tmr_clear;
    logic                  accept, ev_fall, ev_rise, ev_end, ev_idle;
    logic                  last_fall_seen;
    logic [FRAME_BITS-1:0] rx_word;
    logic [CHAN_W-1:0]     dec_chan;
    logic [SAMPLE_W-1:0]   dec_sample;
    logic                  dec_err;

    assign last_fall_seen = (falls_q == BITCNT_W'(FRAME_BITS));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)  state_d = ST_LEAD;
            ST_LEAD:  if (tmr_done) state_d = ST_LOW;
            ST_LOW:   if (tmr_done) state_d = ST_HIGH;
            ST_HIGH:  if (tmr_done) state_d = last_fall_seen ? ST_QUIET : ST_LOW;
            ST_QUIET: if (tmr_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = (state_q == ST_IDLE) && start_i;
        ev_fall   = (state_q != ST_LOW) && (state_d == ST_LOW);
        ev_rise   = (state_q == ST_LOW) && (state_d == ST_HIGH);
        ev_end    = (state_q == ST_HIGH) && (state_d == ST_QUIET);
        ev_idle   = (state_q == ST_QUIET) && (state_d == ST_IDLE);
        tmr_clear = (state_q != state_d) || (state_q == ST_IDLE);
        tmr_limit = (state_q == ST_QUIET) ? TMR_W'(quiet_q) : TMR_W'(half_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q     <= DIV_W'(1);
            quiet_q    <= QUIET_W'(1);
            twos_q     <= 1'b0;
            exp_q      <= '0;
            falls_q    <= '0;
            cs_n_q     <= 1'b1;
            sclk_q     <= 1'b1;
            busy_q     <= 1'b0;
            valid_q    <= 1'b0;
            chan_q     <= '0;
            sample_q   <= '0;
            twos_out_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (accept) begin
                half_q  <= (half_div_i == '0) ? DIV_W'(1) : half_div_i;
                quiet_q <= (quiet_i == '0) ? QUIET_W'(1) : quiet_i;
                twos_q  <= twos_i;
                exp_q   <= exp_chan_i;
                falls_q <= '0;
                cs_n_q  <= 1'b0;
                busy_q  <= 1'b1;
            end
            if (ev_fall) begin
                sclk_q  <= 1'b0;
                falls_q <= falls_q + BITCNT_W'(1);
            end
            if (ev_rise) sclk_q <= 1'b1;
            if (ev_end) begin
                cs_n_q     <= 1'b1;
                valid_q    <= 1'b1;
                chan_q     <= dec_chan;
                sample_q   <= dec_sample;
                twos_out_q <= twos_q;
                err_q      <= dec_err;
            end
            if (ev_idle) busy_q <= 1'b0;
        end
    end

    adc_phase_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .limit_i (tmr_limit),
        .done_o  (tmr_done)
    );

    adc_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .word_i    (ctrl_word_i),
        .advance_i (ev_rise && !last_fall_seen),
        .capture_i (ev_fall),
        .rx_bit_i  (dout_i),
        .tx_bit_o  (din_o),
        .rx_word_o (rx_word)
    );

    adc_result_decode u_dec (
        .frame_i    (rx_word),
        .twos_i     (twos_q),
        .exp_chan_i (exp_q),
        .chan_o     (dec_chan),
        .sample_o   (dec_sample),
        .err_o      (dec_err)
    );

    assign busy_o   = busy_q;
    assign cs_n_o   = cs_n_q;
    assign sclk_o   = sclk_q;
    assign valid_o  = valid_q;
    assign chan_o   = chan_q;
    assign sample_o = sample_q;
    assign twos_o   = twos_out_q;
    assign err_o    = err_q;

    // R3: clock rests high outside the chip-select window
    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);
    // R3: falling edges only inside a frame
    a_r3_fall_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> !cs_n_o);
    // R2: a frame only starts from the idle condition
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(!busy_o));
    // R9: strobe coincides with chip select rising and lasts one cycle
    a_r9_strobe_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> valid_o);
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R10: chip select held high through the quiet interval
    a_r10_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> cs_n_o);
    a_r10_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);
endmodule

// File: tb/test_adc_link_ctrl.sv
module test_adc_link_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] ctrl_word_i = '0;
    logic [7:0]  half_div_i = 8'd1;
    logic [7:0]  quiet_i = 8'd1;
    logic        twos_i = 1'b0;
    logic [1:0]  exp_chan_i = '0;
    logic        dout_i = 1'b0;
    logic        busy_o, cs_n_o, sclk_o, din_o, valid_o, twos_o, err_o;
    logic [1:0]  chan_o;
    logic [11:0] sample_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [15:0] adc_frame = '0;

    always #2 clk = ~clk;

    adc_link_ctrl i_adc_link_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_word_i(ctrl_word_i),
        .half_div_i(half_div_i), .quiet_i(quiet_i), .twos_i(twos_i),
        .exp_chan_i(exp_chan_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .din_o(din_o), .dout_i(dout_i), .valid_o(valid_o),
        .chan_o(chan_o), .sample_o(sample_o), .twos_o(twos_o), .err_o(err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // converter model: shifts frame out and control word in on falling edges
    int          adc_pos = 15;
    logic        adc_prev_sclk = 1'b1;
    logic [15:0] adc_rx = '0;
    always @(negedge clk) begin
        if (cs_n_o) begin
            adc_pos = 15;
        end else if (adc_prev_sclk && !sclk_o) begin
            adc_rx  = {adc_rx[14:0], din_o};
            adc_pos = adc_pos - 1;
        end
        adc_prev_sclk = sclk_o;
        dout_i = (adc_pos >= 0) ? adc_frame[adc_pos] : 1'b0;
    end

    // behavioural reference: time offset since the accepted start
    bit          m_act = 0;
    int          m_p = 0, m_h = 1, m_q = 1;
    logic [15:0] m_ctrl, m_frame;
    logic        m_tw;
    logic [1:0]  m_exp;
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_act = 0;
        end else if (!m_act) begin
            if (start_i) begin
                m_act = 1; m_p = 0;
                m_h = (half_div_i == 0) ? 1 : int'(half_div_i);
                m_q = (quiet_i == 0) ? 1 : int'(quiet_i);
                m_ctrl = ctrl_word_i; m_tw = twos_i; m_exp = exp_chan_i;
                m_frame = adc_frame;
            end
        end else if (m_p + 1 == 33 * m_h + m_q) begin
            m_act = 0;
        end else begin
            m_p++;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int  e_cs, e_sclk, e_valid, e_din, j, r;
            e_cs    = (!m_act || m_p >= 33 * m_h) ? 1 : 0;
            e_valid = (m_act && m_p == 33 * m_h) ? 1 : 0;
            e_sclk  = 1;
            e_din   = 0;
            if (m_act && m_p < 33 * m_h) begin
                if (m_p < m_h) begin
                    e_din = m_ctrl[15];
                end else begin
                    j = (m_p - m_h) / (2 * m_h);
                    r = (m_p - m_h) % (2 * m_h);
                    e_sclk = (r < m_h) ? 0 : 1;
                    if (r < m_h)     e_din = m_ctrl[15 - j];
                    else if (j < 15) e_din = m_ctrl[14 - j];
                    else             e_din = m_ctrl[0];
                end
                check("R4 din", din_o, e_din);
            end
            check("R2/R9 cs_n", cs_n_o, e_cs);
            check("R3 sclk", sclk_o, e_sclk);
            check("R2/R10 busy", busy_o, m_act);
            check("R9 valid", valid_o, e_valid);
            if (e_valid == 1) begin
                logic [11:0] raw;
                raw = m_frame[11:0];
                check("R6 chan", chan_o, m_frame[13:12]);
                check("R5/R7 sample", sample_o, m_tw ? (raw ^ 12'h800) : raw);
                check("R7 coding flag", twos_o, m_tw);
                check("R8 err", err_o,
                      ((m_frame[15:14] != 2'b00) || (m_frame[13:12] != m_exp)) ? 1 : 0);
                check("R4 word received", adc_rx, m_ctrl);
            end
        end
    end

    task automatic run_frame(input int hold, input logic [15:0] ctrl, input logic [7:0] h,
                             input logic [7:0] q, input logic tw, input logic [1:0] ex,
                             input logic [15:0] fr);
        @(negedge clk);
        ctrl_word_i = ctrl; half_div_i = h; quiet_i = q; twos_i = tw;
        exp_chan_i = ex; adc_frame = fr; start_i = 1'b1;
        repeat (hold) @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cs_n", cs_n_o, 1);
        check("R1 sclk", sclk_o, 1);
        check("R1 busy", busy_o, 0);
        check("R1 valid", valid_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(1, 16'hA5C3, 8'd1, 8'd1, 1'b0, 2'd1, {2'b00, 2'd1, 12'h3A7});
        run_frame(1, 16'h1E69, 8'd2, 8'd3, 1'b1, 2'd2, {2'b00, 2'd2, 12'h800});
        run_frame(1, 16'hF00F, 8'd3, 8'd0, 1'b0, 2'd3, {2'b10, 2'd3, 12'h5A5}); // R8 leading bits
        run_frame(1, 16'h8001, 8'd0, 8'd2, 1'b1, 2'd0, {2'b00, 2'd3, 12'h0C3}); // R8 tag, R3 zero divider
        // R2/R10: start held across a whole frame, second frame follows the quiet gap
        run_frame(45, 16'h3CC3, 8'd1, 8'd5, 1'b1, 2'd0, {2'b00, 2'd0, 12'hFFF});
        run_frame(1, 16'h0000, 8'd2, 8'd1, 1'b1, 2'd1, {2'b01, 2'd1, 12'h000});
        run_frame(1, 16'hFFFF, 8'd4, 8'd7, 1'b0, 2'd2, {2'b00, 2'd2, 12'h001});
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule